// File: doc/BRIEF.md
# Floating-Point Register Stack Manager

This block holds the register file of a stack-organised floating-point unit. There are eight 64-bit slots, each with a valid tag bit, and a circular top pointer. Every register name is relative to that pointer. The entry ST(i) is the physical slot (top + i) mod 8. The values are opaque to the block: arithmetic, format conversion and memory traffic happen elsewhere. The block only moves data between slots, tracks occupancy and keeps the control and status words.

A sequencer issues at most one command per clock, qualified by `cmd_valid`. A command can:
- push or pop,
- write, copy into, or exchange with an ST(i) entry,
- move the pointer,
- free the top slot,
- re-initialise the block,
- clear the exception flags,
- load either of the two words.

The entry named by `cmd_idx` appears combinationally on the read port. The status word is always presented with the live top pointer placed in its pointer field. A push onto an occupied slot or a pop of an empty one still completes, but it raises a one-cycle pulse and sets the sticky stack-fault bit.

Top module: `fp_regstack`

## Requirements
- R1: After reset the control word is 0x037F, the status word reads 0x0000, the top pointer is 0 and all eight tags are clear.
- R2: `rd_data` and `rd_tag` show, without a clock edge, the value and tag of physical slot (top + `cmd_idx`) mod 8.
- R3: Push (op 1) first decrements the top pointer modulo 8. It then writes `cmd_data` into the new top slot and sets that slot's tag.
- R4: Pop (op 2) clears the tag of the current top slot and increments the top pointer modulo 8.
- R5: Write (op 3) stores `cmd_data` into ST(`cmd_idx`) and sets its tag, leaving the pointer unchanged.
- R6: Exchange (op 4) swaps the value and tag of ST(0) with those of ST(`cmd_idx`), leaving the pointer unchanged.
- R7: Step-up (op 5) and step-down (op 6) change the pointer by +1 and -1 modulo 8 without touching any tag. Free (op 7) clears the top slot's tag and leaves the pointer unchanged.
- R8: Initialise (op 8) restores the control word to 0x037F and clears the status word, the pointer and all tags.
- R9: Clear-exceptions (op 9) zeroes status bits 7:0 and 15 and keeps bits 14 and 10:8.
- R10: `status_word` is the stored status word with bits 13:11 replaced by the current top pointer. The condition bits sit at 8, 9, 10 and 14, and the stack-fault bit sits at 6.
- R11: Copy (op 10) writes ST(0) into ST(`cmd_idx`) and sets its tag. Copy-and-pop (op 11) does the same and then performs a pop as in R4.
- R12: Load-control (op 12) sets the control word to `cmd_data[15:0]`. Load-status (op 13) sets the stored status word to `cmd_data[15:0]`, with bits 13:11 not stored.
- R13: A push whose target slot is already tagged makes `ovf_pulse` high for exactly the cycle after the command. A pop or copy-and-pop of an untagged top slot does the same on `unf_pulse`. Either case sets status bit 6, and the operation still completes.
- R14: While `cmd_valid` is low, no pointer, tag, slot value, control word or status word changes, whatever `cmd_op` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_idx | input | 3 | Relative register index i for ST(i) |
| cmd_data | input | 64 | Value for push/write; low 16 bits for word loads |
| rd_data | output | 64 | Value of ST(cmd_idx) |
| rd_tag | output | 1 | Tag of ST(cmd_idx) |
| tos_o | output | 3 | Current top pointer |
| tags_o | output | 8 | Tag bits, indexed by physical slot |
| ctrl_word | output | 16 | Control word |
| status_word | output | 16 | Status word with live top pointer in bits 13:11 |
| ovf_pulse | output | 1 | One-cycle push-overflow indication |
| unf_pulse | output | 1 | One-cycle pop-underflow indication |

## Verification
Three pushes with distinct values followed by relative reads separate a correct (top + i) mapping from an absolute or reversed one. The step-up and step-down commands, and a push issued from pointer 0, make the pointer wrap in both directions. A copy-and-pop onto a freed slot and a push onto a tagged slot each trigger exactly one of the two fault pulses, and each time the bench confirms that the data movement still completed. Loading a status pattern with mixed condition and flag bits, then clearing exceptions, shows which bits survive and that the pointer field always follows the live pointer.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_WRITE  = 4'd3,
    OP_XCHG   = 4'd4,
    OP_INCP   = 4'd5,
    OP_DECP   = 4'd6,
    OP_FREE   = 4'd7,
    OP_INIT   = 4'd8,
    OP_CLEX   = 4'd9,
    OP_STORE  = 4'd10,
    OP_STOREP = 4'd11,
    OP_LDCW   = 4'd12,
    OP_LDSW   = 4'd13
  } stk_op_e;

  localparam int          WORD_W      = 16;
  localparam int          SW_TOP_LSB  = 11;
  localparam logic [15:0] SW_TOP_MASK = 16'h3800;
  localparam logic [15:0] SW_CLR_MASK = 16'h80FF;
  localparam int          SW_SF_BIT   = 6;

endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr
  import fpstk_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] tos
);

  logic [PTR_W-1:0] tos_nxt;
  logic             tos_en;

  always_comb begin
    tos_nxt = tos;
    tos_en  = 1'b0;
    unique case (op)
      OP_PUSH, OP_DECP: begin
        tos_nxt = tos - PTR_W'(1);
        tos_en  = 1'b1;
      end
      OP_POP, OP_INCP, OP_STOREP: begin
        tos_nxt = tos + PTR_W'(1);
        tos_en  = 1'b1;
      end
      OP_INIT: begin
        tos_nxt = '0;
        tos_en  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tos <= '0;
    else if (tos_en) tos <= tos_nxt;
  end

endmodule

// File: rtl/fpstk_file.sv
module fpstk_file
  import fpstk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [PTR_W-1:0]  tos,
  input  logic [PTR_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic [DEPTH-1:0]  tags
);

  logic [DATA_W-1:0] slot_v [DEPTH];
  logic [DEPTH-1:0]  tag_v;
  logic [PTR_W-1:0]  phys_i;
  logic [PTR_W-1:0]  phys_dn;

  assign phys_i  = tos + idx;
  assign phys_dn = tos - PTR_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [PTR_W-1:0] SLOT = PTR_W'(g);
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;
    logic              en;
    logic              t_q;
    logic              t_nxt;

    always_comb begin
      nxt   = q;
      en    = 1'b0;
      t_nxt = t_q;
      unique case (op)
        OP_PUSH: if (SLOT == phys_dn) begin
          nxt = wdata; en = 1'b1; t_nxt = 1'b1;
        end
        OP_POP, OP_FREE: if (SLOT == tos) t_nxt = 1'b0;
        OP_WRITE: if (SLOT == phys_i) begin
          nxt = wdata; en = 1'b1; t_nxt = 1'b1;
        end
        OP_XCHG: begin
          if (SLOT == tos) begin
            nxt = slot_v[phys_i]; en = 1'b1; t_nxt = tag_v[phys_i];
          end else if (SLOT == phys_i) begin
            nxt = slot_v[tos]; en = 1'b1; t_nxt = tag_v[tos];
          end
        end
        OP_INIT: t_nxt = 1'b0;
        OP_STORE, OP_STOREP: begin
          if (SLOT == phys_i) begin
            nxt = slot_v[tos]; en = 1'b1; t_nxt = 1'b1;
          end
          if (op == OP_STOREP && SLOT == tos) t_nxt = 1'b0;
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (en) q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) t_q <= 1'b0;
      else        t_q <= t_nxt;
    end

    assign slot_v[g] = q;
    assign tag_v[g]  = t_q;
  end

  assign rd_data = slot_v[phys_i];
  assign rd_tag  = tag_v[phys_i];
  assign tags    = tag_v;

endmodule

// File: rtl/fpstk_ctl.sv
module fpstk_ctl
  import fpstk_pkg::*;
#(
  parameter logic [15:0] CW_INIT = 16'h037F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_op_e           op,
  input  logic [WORD_W-1:0] wword,
  input  logic              stk_fault,
  output logic [WORD_W-1:0] cw,
  output logic [WORD_W-1:0] sw
);

  logic [WORD_W-1:0] cw_nxt;
  logic              cw_en;
  logic [WORD_W-1:0] sw_nxt;
  logic              sw_en;

  always_comb begin
    cw_nxt = cw;
    cw_en  = 1'b0;
    if (op == OP_INIT) begin
      cw_nxt = CW_INIT;
      cw_en  = 1'b1;
    end else if (op == OP_LDCW) begin
      cw_nxt = wword;
      cw_en  = 1'b1;
    end
  end

  always_comb begin
    sw_nxt = sw;
    sw_en  = 1'b0;
    unique case (op)
      OP_INIT: begin sw_nxt = '0;                    sw_en = 1'b1; end
      OP_LDSW: begin sw_nxt = wword & ~SW_TOP_MASK;  sw_en = 1'b1; end
      OP_CLEX: begin sw_nxt = sw & ~SW_CLR_MASK;     sw_en = 1'b1; end
      default: ;
    endcase
    if (stk_fault) begin
      sw_nxt[SW_SF_BIT] = 1'b1;
      sw_en             = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cw <= CW_INIT;
    else if (cw_en) cw <= cw_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw <= '0;
    else if (sw_en) sw <= sw_nxt;
  end

endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
  import fpstk_pkg::*;
#(
  parameter int          DATA_W  = 64,
  parameter int          DEPTH   = 8,
  parameter logic [15:0] CW_INIT = 16'h037F,
  localparam int         PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic [PTR_W-1:0]  tos_o,
  output logic [DEPTH-1:0]  tags_o,
  output logic [15:0]       ctrl_word,
  output logic [15:0]       status_word,
  output logic              ovf_pulse,
  output logic              unf_pulse
);

  logic [1:0]        rst_sync;
  logic              rst_i;
  stk_op_e           op;
  logic              ovf_hit;
  logic              unf_hit;
  logic [WORD_W-1:0] sw_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign op = cmd_valid ? stk_op_e'(cmd_op) : OP_NOP;

  fpstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_i),
    .op    (op),
    .tos   (tos_o)
  );

  fpstk_file #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_file (
    .clk     (clk),
    .rst_n   (rst_i),
    .op      (op),
    .tos     (tos_o),
    .idx     (cmd_idx),
    .wdata   (cmd_data),
    .rd_data (rd_data),
    .rd_tag  (rd_tag),
    .tags    (tags_o)
  );

  assign ovf_hit = (op == OP_PUSH) && tags_o[tos_o - PTR_W'(1)];
  assign unf_hit = (op == OP_POP || op == OP_STOREP) && !tags_o[tos_o];

  fpstk_ctl #(.CW_INIT(CW_INIT)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_i),
    .op        (op),
    .wword     (cmd_data[WORD_W-1:0]),
    .stk_fault (ovf_hit | unf_hit),
    .cw        (ctrl_word),
    .sw        (sw_raw)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ovf_pulse <= 1'b0;
      unf_pulse <= 1'b0;
    end else begin
      ovf_pulse <= ovf_hit;
      unf_pulse <= unf_hit;
    end
  end

  assign status_word = (sw_raw & ~SW_TOP_MASK) | (WORD_W'(tos_o) << SW_TOP_LSB);

endmodule

// File: rtl/fp_regstack_chk.sv
module fp_regstack_chk #(
  parameter int          DEPTH   = 8,
  parameter int          PTR_W   = 3,
  parameter logic [15:0] CW_INIT = 16'h037F
) (
  input logic             clk,
  input logic             rst_i,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [PTR_W-1:0] tos_o,
  input logic [DEPTH-1:0] tags_o,
  input logic [15:0]      ctrl_word,
  input logic [15:0]      status_word,
  input logic             ovf_pulse,
  input logic             unf_pulse
);

  a_r3_push_top: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && cmd_op == 4'd1) |=> (tos_o == $past(tos_o) - PTR_W'(1)) && tags_o[tos_o]);

  a_r4_pop_top: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && cmd_op == 4'd2) |=> (tos_o == $past(tos_o) + PTR_W'(1)) && !tags_o[$past(tos_o)]);

  a_r7_step_keeps_tags: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && (cmd_op == 4'd5 || cmd_op == 4'd6)) |=> tags_o == $past(tags_o));

  a_r8_init_state: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && cmd_op == 4'd8) |=> ctrl_word == CW_INIT && tags_o == '0 && tos_o == '0 && status_word == 16'h0000);

  a_r9_clex_bits: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && cmd_op == 4'd9) |=> (status_word & 16'h80FF) == 16'h0000 && status_word[14:8] == $past(status_word[14:8]));

  a_r13_fault_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (ovf_pulse || unf_pulse) |-> status_word[6]);

  a_r14_idle_hold: assert property (@(posedge clk) disable iff (!rst_i)
    !cmd_valid |=> tos_o == $past(tos_o) && tags_o == $past(tags_o) &&
                   ctrl_word == $past(ctrl_word) && status_word == $past(status_word));

endmodule

bind fp_regstack fp_regstack_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CW_INIT(CW_INIT)) u_chk (
  .clk         (clk),
  .rst_i       (rst_i),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .tos_o       (tos_o),
  .tags_o      (tags_o),
  .ctrl_word   (ctrl_word),
  .status_word (status_word),
  .ovf_pulse   (ovf_pulse),
  .unf_pulse   (unf_pulse)
);

// File: tb/test_fp_regstack.sv
module test_fp_regstack;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [63:0] cmd_data;
  logic [63:0] rd_data;
  logic        rd_tag;
  logic [2:0]  tos_o;
  logic [7:0]  tags_o;
  logic [15:0] ctrl_word;
  logic [15:0] status_word;
  logic        ovf_pulse;
  logic        unf_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] VB = 64'h5555_6666_7777_8888;
  localparam logic [63:0] VC = 64'h9999_AAAA_BBBB_CCCC;
  localparam logic [63:0] VD = 64'hDDDD_EEEE_FFFF_0001;
  localparam logic [63:0] VX = 64'h0123_4567_89AB_CDEF;

  fp_regstack i_fp_regstack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .rd_data(rd_data), .rd_tag(rd_tag),
    .tos_o(tos_o), .tags_o(tags_o), .ctrl_word(ctrl_word),
    .status_word(status_word), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [2:0] idx, input logic [63:0] data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_idx   = idx;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 4'd0;
  endtask

  task automatic peek(input logic [2:0] idx);
    cmd_idx = idx;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", 64'(ctrl_word), 64'h037F);
    chk("R1 status", 64'(status_word), 64'h0);
    chk("R1 tos", 64'(tos_o), 64'h0);
    chk("R1 tags", 64'(tags_o), 64'h0);
  endtask

  task automatic t_push_pop;
    cmd(4'd1, 3'd0, VA);
    chk("R3 tos after first push wraps", 64'(tos_o), 64'd7);
    chk("R13 no overflow on empty slot", 64'(ovf_pulse), 64'd0);
    cmd(4'd1, 3'd0, VB);
    cmd(4'd1, 3'd0, VC);
    chk("R3 tos", 64'(tos_o), 64'd5);
    chk("R3 tags", 64'(tags_o), 64'hE0);
    peek(3'd0); chk("R2 ST0", rd_data, VC);
    peek(3'd1); chk("R2 ST1", rd_data, VB);
    peek(3'd2); chk("R2 ST2", rd_data, VA);
    chk("R2 tag ST2", 64'(rd_tag), 64'd1);
    cmd(4'd2, 3'd0, 64'd0);
    chk("R4 tos", 64'(tos_o), 64'd6);
    chk("R4 tags", 64'(tags_o), 64'hC0);
    chk("R13 no underflow", 64'(unf_pulse), 64'd0);
    peek(3'd0); chk("R4 new ST0", rd_data, VB);
  endtask

  task automatic t_write_xchg;
    cmd(4'd3, 3'd1, VD);
    peek(3'd1); chk("R5 ST1 written", rd_data, VD);
    chk("R5 tos unchanged", 64'(tos_o), 64'd6);
    cmd(4'd4, 3'd1, 64'd0);
    peek(3'd0); chk("R6 ST0 after swap", rd_data, VD);
    peek(3'd1); chk("R6 ST1 after swap", rd_data, VB);
    chk("R6 tos unchanged", 64'(tos_o), 64'd6);
    chk("R6 tags", 64'(tags_o), 64'hC0);
  endtask

  task automatic t_ptr;
    cmd(4'd5, 3'd0, 64'd0);
    chk("R7 step-up tos", 64'(tos_o), 64'd7);
    chk("R7 step-up tags", 64'(tags_o), 64'hC0);
    cmd(4'd6, 3'd0, 64'd0);
    cmd(4'd6, 3'd0, 64'd0);
    chk("R7 step-down tos", 64'(tos_o), 64'd5);
    chk("R7 step-down tags", 64'(tags_o), 64'hC0);
    cmd(4'd5, 3'd0, 64'd0);
    cmd(4'd7, 3'd0, 64'd0);
    chk("R7 free tags", 64'(tags_o), 64'h80);
    chk("R7 free tos", 64'(tos_o), 64'd6);
  endtask

  task automatic t_store;
    cmd(4'd10, 3'd2, 64'd0);
    chk("R11 copy tags", 64'(tags_o), 64'h81);
    peek(3'd2); chk("R11 copy value", rd_data, VD);
    cmd(4'd11, 3'd1, 64'd0);
    chk("R13 underflow pulse", 64'(unf_pulse), 64'd1);
    chk("R11 copy-pop tos", 64'(tos_o), 64'd7);
    chk("R11 copy-pop tags", 64'(tags_o), 64'h81);
    peek(3'd0); chk("R11 copy-pop value", rd_data, VD);
    chk("R10 status with fault and tos", 64'(status_word), 64'h3840);
    @(negedge clk);
    chk("R13 underflow one cycle", 64'(unf_pulse), 64'd0);
  endtask

  task automatic t_words;
    cmd(4'd13, 3'd0, 64'hC5AA);
    chk("R12 load status", 64'(status_word), 64'hFDAA);
    cmd(4'd9, 3'd0, 64'd0);
    chk("R9 clear exceptions", 64'(status_word), 64'h7D00);
    cmd(4'd12, 3'd0, 64'h1234);
    chk("R12 load control", 64'(ctrl_word), 64'h1234);
  endtask

  task automatic t_overflow;
    cmd(4'd5, 3'd0, 64'd0);
    chk("R7 step-up wraps to 0", 64'(tos_o), 64'd0);
    cmd(4'd1, 3'd0, VX);
    chk("R13 overflow pulse", 64'(ovf_pulse), 64'd1);
    chk("R3 push from 0 wraps", 64'(tos_o), 64'd7);
    chk("R13 status fault", 64'(status_word), 64'h7D40);
    peek(3'd0); chk("R13 push still writes", rd_data, VX);
    @(negedge clk);
    chk("R13 overflow one cycle", 64'(ovf_pulse), 64'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 4'd1;
    cmd_data  = VA;
    @(negedge clk);
    @(negedge clk);
    chk("R14 tos held", 64'(tos_o), 64'd7);
    chk("R14 tags held", 64'(tags_o), 64'h81);
    peek(3'd0); chk("R14 ST0 held", rd_data, VX);
    cmd_op = 4'd0;
  endtask

  task automatic t_init;
    cmd(4'd8, 3'd0, 64'd0);
    chk("R8 ctrl", 64'(ctrl_word), 64'h037F);
    chk("R8 status", 64'(status_word), 64'h0);
    chk("R8 tos", 64'(tos_o), 64'h0);
    chk("R8 tags", 64'(tags_o), 64'h0);
  endtask

  initial begin
    #80000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 4'd0;
    cmd_idx   = 3'd0;
    cmd_data  = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_push_pop;
    t_write_xchg;
    t_ptr;
    t_store;
    t_words;
    t_overflow;
    t_idle;
    t_init;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule